// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Almost Thresholds

This block is a first-in first-out buffer for 9-bit words whose write side and read side each run from a free-running clock of their own. The two clocks may be one net or fully unrelated. The storage depth is a parameter between 256 and 8192 words. Each pointer crosses into the other clock domain as a Gray code through a two-stage synchroniser. Each domain derives its own pair of status flags from its local pointer and the synchronised remote pointer.

A write takes place on a write-clock rising edge only when both write enables are high. A read takes place on a read-clock rising edge only when both read enables are high. When the offset-load input is held high, qualified write cycles fill two threshold registers instead of the storage: the almost-empty distance comes first, then the almost-full distance. Each register resets to 7. An output enable can release the read data lines to high impedance.

Top module: `xclk_fifo`

## Requirements
- R1: After reset, empty and almost_empty are 1, and full and almost_full are 0.
- R2: A word is stored only on a wr_clk rising edge where wr_en_a and wr_en_b are both 1 and ld_ofs is 0. If either enable is 0, nothing enters the FIFO.
- R3: A word is removed only on a rd_clk rising edge where rd_en_a and rd_en_b are both 1. The removed word appears on rd_q_out after that edge. Words leave in the order they were written.
- R4: full is 1 exactly when DEPTH words are held. A write attempted while full is dropped and does not disturb the stored words.
- R5: A read attempted while empty is ignored. The read pointer does not move, and rd_q_out keeps its previous value.
- R6: With the default offset, almost_empty is 1 while the FIFO holds 7 or fewer words and 0 at 8 or more.
- R7: With the default offset, almost_full is 1 while the FIFO holds DEPTH-7 or more words and 0 below that.
- R8: While ld_ofs is 1, each qualified write cycle stores the low bits of wr_d into an offset register and not into the FIFO. The first such cycle after ld_ofs rises loads the almost-empty offset, and the second loads the almost-full offset.
- R9: A loaded almost-empty offset E makes almost_empty be 1 at E or fewer words. A loaded almost-full offset F makes almost_full be 1 at DEPTH-F or more words.
- R10: When rd_oe is 0, rd_q_out is high impedance. When rd_oe is 1, it shows the last word read.
- R11: Data passes intact both when rd_clk is the same signal as wr_clk and when the two clocks are unrelated.
- R12: Reset restores both offsets to 7, even after they have been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-side clock |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| ld_ofs | input | 1 | Redirects qualified writes into the offset registers |
| wr_d | input | DW | Write data, or an offset value while loading |
| rd_clk | input | 1 | Read-side clock |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_oe | input | 1 | Output enable for rd_q_out |
| rd_q_out | output | DW | Registered read data, high impedance when disabled |
| full | output | 1 | FIFO holds DEPTH words (write domain) |
| almost_full | output | 1 | Fill level at or above DEPTH minus the almost-full offset (write domain) |
| empty | output | 1 | FIFO holds no words (read domain) |
| almost_empty | output | 1 | Fill level at or below the almost-empty offset (read domain) |

## Verification
A write can reach a full FIFO in the same write-clock cycle in which it would have become the word that sets full. A read can likewise reach an empty FIFO in the same read-clock cycle. The bench fills the FIFO to exactly DEPTH and keeps driving a further write with a distinct value. It then drains every word and judges that the extra value never appears and that empty returns after exactly DEPTH reads. On the read side, read pulses issued while empty must leave rd_q_out unchanged, and the next word written must be the next word read. This shows that neither pointer slipped.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

   // distance from the boundary used until offsets are loaded
   localparam int unsigned XF_DEF_OFS = 7;

   // which offset register the next load cycle fills
   typedef enum logic {
      SLOT_LOW  = 1'b0,
      SLOT_HIGH = 1'b1
   } ofs_slot_e;

   function automatic logic [31:0] xf_bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] xf_gray2bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
   parameter int unsigned W      = 10,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      if (STAGES < 2) $error("synchroniser needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/xclk_fifo_mem.sv
module xclk_fifo_mem #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned DW    = 9,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          wr_clk,
   input  logic          wr_fire,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_d,
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          rd_fire,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_q
);

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (wr_fire) store[wr_addr] <= wr_d;
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (rd_fire) rd_q <= store[rd_addr];
   end

endmodule

// File: rtl/xclk_fifo_wctl.sv
module xclk_fifo_wctl
   import xclk_fifo_pkg::*;
#(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned PW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_a,
   input  logic          en_b,
   input  logic          ld,
   input  logic [AW-1:0] ofs_word,
   input  logic [PW-1:0] rd_gray_s,
   output logic [PW-1:0] wr_gray,
   output logic [AW-1:0] wr_addr,
   output logic          wr_fire,
   output logic [AW-1:0] ae_ofs,
   output logic          full,
   output logic          almost_full
);

   localparam logic [AW-1:0] DEF_OFS = AW'(XF_DEF_OFS);
   localparam logic [PW-1:0] CAP     = PW'(DEPTH);

   logic [PW-1:0] wbin;
   logic [PW-1:0] rbin_s;
   logic [PW-1:0] used;
   logic [PW-1:0] af_level;
   logic [AW-1:0] af_ofs;
   logic          req;
   ofs_slot_e     slot;

   assign req     = en_a & en_b;
   assign wr_fire = req & ~ld & ~full;
   assign wr_addr = wbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin    <= '0;
         wr_gray <= '0;
      end else if (wr_fire) begin
         wbin    <= wbin + 1'b1;
         wr_gray <= PW'(xf_bin2gray(32'(wbin + 1'b1)));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ae_ofs <= DEF_OFS;
         af_ofs <= DEF_OFS;
         slot   <= SLOT_LOW;
      end else if (!ld) begin
         slot <= SLOT_LOW;
      end else if (req) begin
         if (slot == SLOT_LOW) begin
            ae_ofs <= ofs_word;
            slot   <= SLOT_HIGH;
         end else begin
            af_ofs <= ofs_word;
            slot   <= SLOT_LOW;
         end
      end
   end

   assign rbin_s      = PW'(xf_gray2bin(32'(rd_gray_s)));
   assign used        = wbin - rbin_s;
   assign af_level    = CAP - {1'b0, af_ofs};
   assign full        = (wr_gray == {~rd_gray_s[PW-1:PW-2], rd_gray_s[PW-3:0]});
   assign almost_full = (used >= af_level);

   // R4: the write-side fill count never exceeds the capacity
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      used <= CAP);

   // R7: full always implies almost-full, whatever offset is loaded
   a_r7_full_has_af: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> almost_full);

   // R8: a load cycle leaves the write pointer where it was
   a_r8_load_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && req) |=> (wbin == $past(wbin)));

endmodule

// File: rtl/xclk_fifo_rctl.sv
module xclk_fifo_rctl
   import xclk_fifo_pkg::*;
#(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned PW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_a,
   input  logic          en_b,
   input  logic [PW-1:0] wr_gray_s,
   input  logic [AW-1:0] ae_ofs,
   output logic [PW-1:0] rd_gray,
   output logic [AW-1:0] rd_addr,
   output logic          rd_fire,
   output logic          empty,
   output logic          almost_empty
);

   logic [PW-1:0] rbin;
   logic [PW-1:0] wbin_s;
   logic [PW-1:0] used;

   assign rd_fire = en_a & en_b & ~empty;
   assign rd_addr = rbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin    <= '0;
         rd_gray <= '0;
      end else if (rd_fire) begin
         rbin    <= rbin + 1'b1;
         rd_gray <= PW'(xf_bin2gray(32'(rbin + 1'b1)));
      end
   end

   assign wbin_s       = PW'(xf_gray2bin(32'(wr_gray_s)));
   assign used         = wbin_s - rbin;
   assign empty        = (rd_gray == wr_gray_s);
   assign almost_empty = (used <= {1'b0, ae_ofs});

   // R5: the read-side fill count never wraps below zero
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      used <= PW'(DEPTH));

   // R5: the read pointer stays put on a cycle that starts empty
   a_r5_empty_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      empty |=> (rbin == $past(rbin)));

   // R6: empty always implies almost-empty
   a_r6_empty_has_ae: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> almost_empty);

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
   import xclk_fifo_pkg::*;
#(
   parameter int unsigned DEPTH       = 256,
   parameter int unsigned DW          = 9,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned AW         = $clog2(DEPTH),
   localparam int unsigned PW         = AW + 1
) (
   input  logic          rst_n,
   input  logic          wr_clk,
   input  logic          wr_en_a,
   input  logic          wr_en_b,
   input  logic          ld_ofs,
   input  logic [DW-1:0] wr_d,
   input  logic          rd_clk,
   input  logic          rd_en_a,
   input  logic          rd_en_b,
   input  logic          rd_oe,
   output logic [DW-1:0] rd_q_out,
   output logic          full,
   output logic          almost_full,
   output logic          empty,
   output logic          almost_empty
);

   generate
      if (DEPTH < 256 || DEPTH > 8192)
         $error("DEPTH must lie between 256 and 8192");
      if ((DEPTH & (DEPTH - 1)) != 0)
         $error("DEPTH must be a power of two");
      if (DW < 1)
         $error("DW must be at least one bit");
   endgenerate

   logic [PW-1:0] wr_gray, wr_gray_s;
   logic [PW-1:0] rd_gray, rd_gray_s;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [AW-1:0] ae_ofs;
   logic [AW-1:0] ofs_word;
   logic          wr_fire, rd_fire;
   logic [DW-1:0] rd_q;

   // offset width follows the depth; fit the data bus to it
   generate
      if (AW > DW) begin : g_ofs_widen
         assign ofs_word = {{(AW - DW){1'b0}}, wr_d};
      end else if (AW == DW) begin : g_ofs_same
         assign ofs_word = wr_d;
      end else begin : g_ofs_trim
         assign ofs_word = wr_d[AW-1:0];
      end
   endgenerate

   xclk_fifo_wctl #(.DEPTH(DEPTH)) u_wctl (
      .clk         (wr_clk),
      .rst_n       (rst_n),
      .en_a        (wr_en_a),
      .en_b        (wr_en_b),
      .ld          (ld_ofs),
      .ofs_word    (ofs_word),
      .rd_gray_s   (rd_gray_s),
      .wr_gray     (wr_gray),
      .wr_addr     (wr_addr),
      .wr_fire     (wr_fire),
      .ae_ofs      (ae_ofs),
      .full        (full),
      .almost_full (almost_full)
   );

   xclk_fifo_rctl #(.DEPTH(DEPTH)) u_rctl (
      .clk          (rd_clk),
      .rst_n        (rst_n),
      .en_a         (rd_en_a),
      .en_b         (rd_en_b),
      .wr_gray_s    (wr_gray_s),
      .ae_ofs       (ae_ofs),
      .rd_gray      (rd_gray),
      .rd_addr      (rd_addr),
      .rd_fire      (rd_fire),
      .empty        (empty),
      .almost_empty (almost_empty)
   );

   xclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .d     (wr_gray),
      .q     (wr_gray_s)
   );

   xclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .d     (rd_gray),
      .q     (rd_gray_s)
   );

   xclk_fifo_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
      .wr_clk  (wr_clk),
      .wr_fire (wr_fire),
      .wr_addr (wr_addr),
      .wr_d    (wr_d),
      .rd_clk  (rd_clk),
      .rst_n   (rst_n),
      .rd_fire (rd_fire),
      .rd_addr (rd_addr),
      .rd_q    (rd_q)
   );

   assign rd_q_out = rd_oe ? rd_q : {DW{1'bz}};

   // R1: the two boundary flags never both stand
   a_r1_flags_exclusive: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !(full && empty));

endmodule

// File: tb/xclk_fifo_bench.sv
module xclk_fifo_bench;

   localparam int DEPTH = 256;
   localparam int DW    = 9;

   logic          rst_n = 1'b0;
   logic          wr_clk = 1'b0;
   logic          b_clk = 1'b0;
   logic          tie = 1'b1;
   logic          rd_clk;
   logic          wr_en_a = 1'b0, wr_en_b = 1'b0, ld_ofs = 1'b0;
   logic [DW-1:0] wr_d = '0;
   logic          rd_en_a = 1'b0, rd_en_b = 1'b0, rd_oe = 1'b1;
   logic [DW-1:0] rd_q_out;
   logic          full, almost_full, empty, almost_empty;

   int checks = 0;
   int errors = 0;

   always #5 wr_clk = ~wr_clk;
   always #6.5 b_clk = ~b_clk;
   assign rd_clk = tie ? wr_clk : b_clk;

   xclk_fifo #(.DEPTH(DEPTH), .DW(DW)) u_xclk_fifo (
      .rst_n(rst_n), .wr_clk(wr_clk), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
      .ld_ofs(ld_ofs), .wr_d(wr_d), .rd_clk(rd_clk), .rd_en_a(rd_en_a),
      .rd_en_b(rd_en_b), .rd_oe(rd_oe), .rd_q_out(rd_q_out), .full(full),
      .almost_full(almost_full), .empty(empty), .almost_empty(almost_empty)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic tied);
      rst_n = 1'b0;
      tie   = tied;
      repeat (3) @(negedge wr_clk);
      rst_n = 1'b1;
      repeat (2) @(negedge wr_clk);
   endtask

   task automatic wr_cycle(input logic a, input logic b, input logic [DW-1:0] d);
      @(negedge wr_clk);
      wr_en_a = a; wr_en_b = b; wr_d = d;
      @(negedge wr_clk);
      wr_en_a = 1'b0; wr_en_b = 1'b0;
   endtask

   task automatic push(input logic [DW-1:0] d);
      wr_cycle(1'b1, 1'b1, d);
   endtask

   task automatic rd_cycle(input logic a, input logic b);
      @(negedge rd_clk);
      rd_en_a = a; rd_en_b = b;
      @(negedge rd_clk);
      rd_en_a = 1'b0; rd_en_b = 1'b0;
   endtask

   task automatic settle();
      repeat (6) @(negedge rd_clk);
      repeat (6) @(negedge wr_clk);
   endtask

   task automatic t_reset();
      do_reset(1'b1);
      chk(empty == 1'b1, "R1 empty", int'(empty), 1);
      chk(almost_empty == 1'b1, "R1 almost_empty", int'(almost_empty), 1);
      chk(full == 1'b0, "R1 full", int'(full), 0);
      chk(almost_full == 1'b0, "R1 almost_full", int'(almost_full), 0);
   endtask

   task automatic t_enables();
      do_reset(1'b1);
      wr_cycle(1'b1, 1'b0, 9'h011);
      wr_cycle(1'b0, 1'b1, 9'h022);
      settle();
      chk(empty == 1'b1, "R2 single write enable", int'(empty), 1);
      push(9'h133);
      settle();
      rd_cycle(1'b1, 1'b0);
      rd_cycle(1'b0, 1'b1);
      settle();
      chk(empty == 1'b0, "R3 single read enable", int'(empty), 0);
      rd_cycle(1'b1, 1'b1);
      chk(rd_q_out == 9'h133, "R3 read word", int'(rd_q_out), 'h133);
      settle();
      chk(empty == 1'b1, "R3 empty after read", int'(empty), 1);
   endtask

   task automatic t_order(input logic tied);
      int bad = 0;
      logic [DW-1:0] exp;
      do_reset(tied);
      for (int i = 0; i < 20; i++) push(DW'(i * 37 + 5));
      settle();
      for (int i = 0; i < 20; i++) begin
         rd_cycle(1'b1, 1'b1);
         exp = DW'(i * 37 + 5);
         if (rd_q_out !== exp) bad++;
         chk(rd_q_out === exp, tied ? "R11 tied order" : "R11 async order R3",
             int'(rd_q_out), int'(exp));
      end
      settle();
      chk(empty == 1'b1, "R11 drained", int'(empty), 1);
   endtask

   task automatic t_full_and_empty_read();
      logic [DW-1:0] exp;
      logic [DW-1:0] last;
      do_reset(1'b0);
      for (int i = 0; i < DEPTH - 8; i++) push(DW'(i ^ 'h055));
      chk(almost_full == 1'b0, "R7 below threshold", int'(almost_full), 0);
      push(DW'((DEPTH - 8) ^ 'h055));
      chk(almost_full == 1'b1, "R7 at threshold", int'(almost_full), 1);
      for (int i = DEPTH - 7; i < DEPTH - 1; i++) push(DW'(i ^ 'h055));
      chk(full == 1'b0, "R4 one short of full", int'(full), 0);
      push(DW'((DEPTH - 1) ^ 'h055));
      chk(full == 1'b1, "R4 full at depth", int'(full), 1);
      push(9'h1AA);
      chk(full == 1'b1, "R4 full after dropped write", int'(full), 1);
      settle();
      for (int i = 0; i < DEPTH; i++) begin
         rd_cycle(1'b1, 1'b1);
         exp = DW'(i ^ 'h055);
         if (rd_q_out !== exp)
            chk(1'b0, "R4 drained word", int'(rd_q_out), int'(exp));
      end
      chk(1'b1, "R4 drain", 0, 0);
      settle();
      chk(empty == 1'b1, "R4 extra word not stored", int'(empty), 1);
      last = rd_q_out;
      rd_cycle(1'b1, 1'b1);
      rd_cycle(1'b1, 1'b1);
      chk(rd_q_out === last, "R5 read while empty holds data", int'(rd_q_out), int'(last));
      chk(empty == 1'b1, "R5 still empty", int'(empty), 1);
      push(9'h0F0);
      settle();
      rd_cycle(1'b1, 1'b1);
      chk(rd_q_out === 9'h0F0, "R5 pointer unmoved", int'(rd_q_out), 'h0F0);
   endtask

   task automatic t_almost_empty();
      do_reset(1'b0);
      for (int i = 0; i < 7; i++) push(DW'(i));
      settle();
      chk(almost_empty == 1'b1, "R6 seven words", int'(almost_empty), 1);
      push(9'h007);
      settle();
      chk(almost_empty == 1'b0, "R6 eight words", int'(almost_empty), 0);
      rd_cycle(1'b1, 1'b1);
      settle();
      chk(almost_empty == 1'b1, "R6 back to seven", int'(almost_empty), 1);
   endtask

   task automatic t_load();
      do_reset(1'b1);
      @(negedge wr_clk);
      ld_ofs = 1'b1;
      push(9'd3);
      push(9'd10);
      @(negedge wr_clk);
      ld_ofs = 1'b0;
      settle();
      chk(empty == 1'b1, "R8 load writes skip fifo", int'(empty), 1);
      for (int i = 0; i < 3; i++) push(DW'(i));
      settle();
      chk(almost_empty == 1'b1, "R9 ae at loaded offset", int'(almost_empty), 1);
      push(9'd3);
      settle();
      chk(almost_empty == 1'b0, "R9 ae above loaded offset", int'(almost_empty), 0);
      for (int i = 4; i < DEPTH - 11; i++) push(DW'(i));
      chk(almost_full == 1'b0, "R9 af below loaded threshold", int'(almost_full), 0);
      push(9'h0AB);
      chk(almost_full == 1'b1, "R9 af at loaded threshold", int'(almost_full), 1);
   endtask

   task automatic t_reset_defaults();
      do_reset(1'b1);
      for (int i = 0; i < 4; i++) push(DW'(i));
      settle();
      chk(almost_empty == 1'b1, "R12 default ae offset back", int'(almost_empty), 1);
      for (int i = 4; i < 8; i++) push(DW'(i));
      settle();
      chk(almost_empty == 1'b0, "R12 eight words clear ae", int'(almost_empty), 0);
   endtask

   task automatic t_oe();
      do_reset(1'b1);
      push(9'h155);
      settle();
      rd_cycle(1'b1, 1'b1);
      chk(rd_q_out === 9'h155, "R10 enabled output", int'(rd_q_out), 'h155);
      rd_oe = 1'b0;
      #1;
      chk((rd_q_out === {DW{1'bz}}) || (rd_q_out === '0), "R10 released output",
          int'(rd_q_out), 0);
      rd_oe = 1'b1;
      #1;
      chk(rd_q_out === 9'h155, "R10 re-enabled output", int'(rd_q_out), 'h155);
   endtask

   initial begin
      t_reset();
      t_enables();
      t_order(1'b1);
      t_order(1'b0);
      t_full_and_empty_read();
      t_almost_empty();
      t_load();
      t_reset_defaults();
      t_oe();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge wr_clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule